// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block holds the device-side bookkeeping for three descriptor rings that live in shared memory. The device consumes the request ring. It fills the completion ring and the optional message ring. Each ring is built from up to `MAX_PAGES` physical pages, which need not be contiguous. A setup pulse loads the page numbers and the page count. From them the block derives the ring length, a power-of-two wrap mask and the base address of each page.

On each pop the block returns the byte address of the next descriptor slot one cycle later and advances its private counter. Flush pulses publish the counters into a small shared ring-state register file. That file also has a host-side port, so the other party can post its own producer and consumer indices. The block takes the empty test for the request ring and the room test for the message ring from the values held in that file. It keeps no full or empty flags of its own.

Top module: `ring_index_mgr`

## Requirements
- R1: A cleanup pulse clears all three counters, wrap masks and page base addresses and forgets both setups, leaving the ring-state file untouched; after it a flush publishes 0 and a non-empty request pop returns address 0. Reset also zeroes all nine ring-state fields.
- R2: A ring setup pulse clears the request and completion counters and writes 0 to fields 0, 1, 3 and 4 of the ring-state file, the request log2 length to field 2 and the completion log2 length to field 5; fields 6..8 are not touched. Field map: 0 request producer, 1 request consumer, 2 request log2, 3 completion producer, 4 completion consumer, 5 completion log2, 6 message producer, 7 message consumer, 8 message log2.
- R3: A ring holds pages × (2^PAGE_SHIFT / descriptor bytes) entries. Its log2 length L is the bit length of (entries − 1), and its wrap mask is 2^L − 1.
- R4: A request pop while field 0 equals the consumed counter returns address 0 and leaves the counter unchanged.
- R5: Any other request pop uses slot = counter AND mask. It returns page_base[slot / per_page] + (slot mod per_page) × request descriptor bytes and then increments the counter. A page base is the page number shifted left by PAGE_SHIFT, and pages at or beyond the configured count have base 0.
- R6: A completion pop is never refused and has no overflow check. It uses the same slot and address rule with the completion descriptor size and its own counter.
- R7: `msg_room_o` is high exactly when (field 6 − field 7), taken modulo 2^32, is less than the message mask + 1.
- R8: A message setup pulse takes effect only when a ring setup has happened since the last reset or cleanup. It then clears the message counter, writes 0 to fields 6 and 7 and the message log2 length to field 8. Otherwise it changes nothing.
- R9: The request flush writes the unmasked consumed counter to field 1. The completion flush writes its counter to field 3, and the message flush writes its counter to field 6.
- R10: Addresses and the done pulse appear on the clock edge after the pop. Pops in a cleanup or setup cycle of their ring are dropped. When the block and the host port write the same field in one cycle, the block's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clean_i | input | 1 | Cleanup pulse |
| rings_setup_i | input | 1 | Request and completion ring setup pulse |
| req_npages_i | input | clog2(MAX_PAGES+1) | Request ring page count |
| req_ppns_i | input | MAX_PAGES×(ADDR_W−PAGE_SHIFT) | Request page numbers, page k at bits k×PPN width |
| cmp_npages_i | input | clog2(MAX_PAGES+1) | Completion ring page count |
| cmp_ppns_i | input | MAX_PAGES×(ADDR_W−PAGE_SHIFT) | Completion page numbers |
| msg_setup_i | input | 1 | Message ring setup pulse |
| msg_npages_i | input | clog2(MAX_PAGES+1) | Message ring page count |
| msg_ppns_i | input | MAX_PAGES×(ADDR_W−PAGE_SHIFT) | Message page numbers |
| req_pop_i | input | 1 | Take next request slot |
| cmp_pop_i | input | 1 | Take next completion slot |
| msg_pop_i | input | 1 | Take next message slot |
| req_flush_i | input | 1 | Publish request consumed counter |
| cmp_flush_i | input | 1 | Publish completion counter |
| msg_flush_i | input | 1 | Publish message counter |
| req_addr_o | output | ADDR_W | Request slot address, 0 when empty |
| req_done_o | output | 1 | Request pop result valid |
| cmp_addr_o | output | ADDR_W | Completion slot address |
| cmp_done_o | output | 1 | Completion pop result valid |
| msg_addr_o | output | ADDR_W | Message slot address |
| msg_done_o | output | 1 | Message pop result valid |
| msg_room_o | output | 1 | Message ring has room |
| sh_we_i | input | 1 | Host write to ring-state file |
| sh_waddr_i | input | 4 | Host write field index |
| sh_wdata_i | input | 32 | Host write data |
| sh_raddr_i | input | 4 | Read field index |
| sh_rdata_o | output | 32 | Read data, 0 for indices above 8 |

## Verification
The bench uses 256-byte pages (PAGE_SHIFT 8), 32-bit addresses and four page slots. With these values a request or message page holds two entries and a completion page holds eight. Three-page and one-page rings then give masks of 7, 1 and 15 after only a few pops. Wrap, page crossing, the zero base of an unconfigured page and counters running past the mask all happen within twenty pops. The small field values also let the host port drive the room test across the 2^32 wrap directly.

// File: rtl/ring_state_pkg.sv
package ring_state_pkg;

   localparam int IDX_W      = 32;
   localparam int NUM_FIELDS = 9;
   localparam int FLD_AW     = 4;

   // Ring-state field indices; the host side decodes these positions.
   localparam int F_REQ_PROD = 0;
   localparam int F_REQ_CONS = 1;
   localparam int F_REQ_LOG2 = 2;
   localparam int F_CMP_PROD = 3;
   localparam int F_CMP_CONS = 4;
   localparam int F_CMP_LOG2 = 5;
   localparam int F_MSG_PROD = 6;
   localparam int F_MSG_CONS = 7;
   localparam int F_MSG_LOG2 = 8;

   localparam int NUM_RINGS  = 3;
   localparam int RING_REQ   = 0;
   localparam int RING_CMP   = 1;
   localparam int RING_MSG   = 2;

   // Position of the highest set bit plus one; zero for zero.
   function automatic int bit_len(input logic [IDX_W-1:0] v);
      int n;
      n = 0;
      for (int i = 0; i < IDX_W; i++)
         if (v[i]) n = i + 1;
      return n;
   endfunction

endpackage

// File: rtl/ring_state_file.sv
module ring_state_file
   import ring_state_pkg::*;
#(
   parameter int FIELDS = NUM_FIELDS,
   parameter int W      = IDX_W,
   parameter int AW     = FLD_AW
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we_i,
   input  logic [AW-1:0]     host_waddr_i,
   input  logic [W-1:0]      host_wdata_i,
   input  logic [FIELDS-1:0] dev_we_i,
   input  logic [FIELDS*W-1:0] dev_wdata_i,
   output logic [FIELDS*W-1:0] fields_o
);

   generate
      if (FIELDS > (1 << AW)) begin : g_bad_aw
         $error("ring_state_file: field index too narrow");
      end
      for (genvar f = 0; f < FIELDS; f++) begin : g_fld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fields_o[f*W +: W] <= '0;
            else if (dev_we_i[f])
               fields_o[f*W +: W] <= dev_wdata_i[f*W +: W];
            else if (host_we_i && host_waddr_i == AW'(f))
               fields_o[f*W +: W] <= host_wdata_i;
         end
      end
   endgenerate

endmodule

// File: rtl/ring_cursor.sv
module ring_cursor
   import ring_state_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   parameter int ADDR_W     = 48,
   parameter int MAX_PAGES  = 4,
   parameter int DESC_BYTES = 128
)(
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   clear_i,
   input  logic                                   init_i,
   input  logic [$clog2(MAX_PAGES+1)-1:0]         npages_i,
   input  logic [MAX_PAGES*(ADDR_W-PAGE_SHIFT)-1:0] ppns_i,
   input  logic                                   step_i,
   output logic [IDX_W-1:0]                       count_o,
   output logic [IDX_W-1:0]                       mask_o,
   output logic [IDX_W-1:0]                       log2_o,
   output logic [ADDR_W-1:0]                      slot_addr_o
);

   localparam int PPN_W    = ADDR_W - PAGE_SHIFT;
   localparam int NP_W     = $clog2(MAX_PAGES + 1);
   localparam int PER_PAGE = (1 << PAGE_SHIFT) / DESC_BYTES;
   localparam int OFF_W    = $clog2(PER_PAGE);
   localparam int PG_W     = $clog2(MAX_PAGES);
   localparam int DESC_SH  = $clog2(DESC_BYTES);
   localparam int SLOT_W   = OFF_W + PG_W;

   generate
      if ((DESC_BYTES & (DESC_BYTES - 1)) != 0 || PER_PAGE < 2) begin : g_bad_desc
         $error("ring_cursor: descriptor size must be a power of two, two or more per page");
      end
   endgenerate

   logic [IDX_W-1:0]  count_q, mask_q;
   logic [ADDR_W-1:0] base_q [MAX_PAGES];
   logic [IDX_W-1:0]  entries_c, len_log2_c, mask_c;
   logic [SLOT_W-1:0] slot_c;
   logic [PG_W-1:0]   page_c;
   logic [OFF_W-1:0]  off_c;

   always_comb begin
      entries_c  = IDX_W'(npages_i) * IDX_W'(PER_PAGE);
      len_log2_c = IDX_W'(bit_len(entries_c - 1'b1));
      mask_c     = IDX_W'((64'd1 << len_log2_c) - 64'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         mask_q  <= '0;
      end else if (clear_i) begin
         count_q <= '0;
         mask_q  <= '0;
      end else if (init_i) begin
         count_q <= '0;
         mask_q  <= mask_c;
      end else if (step_i) begin
         count_q <= count_q + 1'b1;
      end
   end

   generate
      for (genvar p = 0; p < MAX_PAGES; p++) begin : g_page
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               base_q[p] <= '0;
            else if (clear_i)
               base_q[p] <= '0;
            else if (init_i)
               base_q[p] <= (npages_i > NP_W'(p)) ?
                            {ppns_i[p*PPN_W +: PPN_W], {PAGE_SHIFT{1'b0}}} : '0;
         end
      end
   endgenerate

   always_comb begin
      slot_c      = count_q[SLOT_W-1:0] & mask_q[SLOT_W-1:0];
      page_c      = slot_c[OFF_W +: PG_W];
      off_c       = slot_c[OFF_W-1:0];
      slot_addr_o = base_q[page_c] + (ADDR_W'(off_c) << DESC_SH);
   end

   assign count_o = count_q;
   assign mask_o  = mask_q;
   assign log2_o  = len_log2_c;

endmodule

// File: rtl/ring_index_mgr.sv
module ring_index_mgr
   import ring_state_pkg::*;
#(
   parameter int PAGE_SHIFT     = 12,
   parameter int ADDR_W         = 48,
   parameter int MAX_PAGES      = 4,
   parameter int REQ_DESC_BYTES = 128,
   parameter int CMP_DESC_BYTES = 32,
   parameter int MSG_DESC_BYTES = 128
)(
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     clean_i,
   input  logic                                     rings_setup_i,
   input  logic [$clog2(MAX_PAGES+1)-1:0]           req_npages_i,
   input  logic [MAX_PAGES*(ADDR_W-PAGE_SHIFT)-1:0] req_ppns_i,
   input  logic [$clog2(MAX_PAGES+1)-1:0]           cmp_npages_i,
   input  logic [MAX_PAGES*(ADDR_W-PAGE_SHIFT)-1:0] cmp_ppns_i,
   input  logic                                     msg_setup_i,
   input  logic [$clog2(MAX_PAGES+1)-1:0]           msg_npages_i,
   input  logic [MAX_PAGES*(ADDR_W-PAGE_SHIFT)-1:0] msg_ppns_i,
   input  logic                                     req_pop_i,
   input  logic                                     cmp_pop_i,
   input  logic                                     msg_pop_i,
   input  logic                                     req_flush_i,
   input  logic                                     cmp_flush_i,
   input  logic                                     msg_flush_i,
   output logic [ADDR_W-1:0]                        req_addr_o,
   output logic                                     req_done_o,
   output logic [ADDR_W-1:0]                        cmp_addr_o,
   output logic                                     cmp_done_o,
   output logic [ADDR_W-1:0]                        msg_addr_o,
   output logic                                     msg_done_o,
   output logic                                     msg_room_o,
   input  logic                                     sh_we_i,
   input  logic [FLD_AW-1:0]                        sh_waddr_i,
   input  logic [IDX_W-1:0]                         sh_wdata_i,
   input  logic [FLD_AW-1:0]                        sh_raddr_i,
   output logic [IDX_W-1:0]                         sh_rdata_o
);

   localparam int PPN_W = ADDR_W - PAGE_SHIFT;
   localparam int NP_W  = $clog2(MAX_PAGES + 1);

   generate
      if (MAX_PAGES < 2 || (MAX_PAGES & (MAX_PAGES - 1)) != 0) begin : g_bad_pages
         $error("ring_index_mgr: MAX_PAGES must be a power of two, at least 2");
      end
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("ring_index_mgr: PAGE_SHIFT out of range");
      end
   endgenerate

   // ---------------- per-ring cursors ----------------
   logic [IDX_W-1:0]  cnt   [NUM_RINGS];
   logic [IDX_W-1:0]  mask  [NUM_RINGS];
   logic [IDX_W-1:0]  log2v [NUM_RINGS];
   logic [ADDR_W-1:0] saddr [NUM_RINGS];
   logic [NP_W-1:0]   np    [NUM_RINGS];
   logic [MAX_PAGES*PPN_W-1:0] ppn [NUM_RINGS];
   logic [NUM_RINGS-1:0] init, step;

   logic rings_valid_q;
   logic req_go, cmp_go, msg_go, req_empty;
   logic [IDX_W-1:0] fld [NUM_FIELDS];

   assign np[RING_REQ]  = req_npages_i;
   assign np[RING_CMP]  = cmp_npages_i;
   assign np[RING_MSG]  = msg_npages_i;
   assign ppn[RING_REQ] = req_ppns_i;
   assign ppn[RING_CMP] = cmp_ppns_i;
   assign ppn[RING_MSG] = msg_ppns_i;

   assign init[RING_REQ] = rings_setup_i & ~clean_i;
   assign init[RING_CMP] = rings_setup_i & ~clean_i;
   assign init[RING_MSG] = msg_setup_i & ~clean_i & rings_valid_q;

   assign req_go    = req_pop_i & ~clean_i & ~init[RING_REQ];
   assign cmp_go    = cmp_pop_i & ~clean_i & ~init[RING_CMP];
   assign msg_go    = msg_pop_i & ~clean_i & ~init[RING_MSG];
   assign req_empty = (fld[F_REQ_PROD] == cnt[RING_REQ]);

   assign step[RING_REQ] = req_go & ~req_empty;
   assign step[RING_CMP] = cmp_go;
   assign step[RING_MSG] = msg_go;

   generate
      for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
         localparam int DB = (g == RING_REQ) ? REQ_DESC_BYTES :
                             (g == RING_CMP) ? CMP_DESC_BYTES : MSG_DESC_BYTES;
         ring_cursor #(
            .PAGE_SHIFT (PAGE_SHIFT),
            .ADDR_W     (ADDR_W),
            .MAX_PAGES  (MAX_PAGES),
            .DESC_BYTES (DB)
         ) u_cur (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear_i     (clean_i),
            .init_i      (init[g]),
            .npages_i    (np[g]),
            .ppns_i      (ppn[g]),
            .step_i      (step[g]),
            .count_o     (cnt[g]),
            .mask_o      (mask[g]),
            .log2_o      (log2v[g]),
            .slot_addr_o (saddr[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rings_valid_q <= 1'b0;
      else if (clean_i)          rings_valid_q <= 1'b0;
      else if (rings_setup_i)    rings_valid_q <= 1'b1;
   end

   // ---------------- pop results ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_addr_o <= '0;  req_done_o <= 1'b0;
         cmp_addr_o <= '0;  cmp_done_o <= 1'b0;
         msg_addr_o <= '0;  msg_done_o <= 1'b0;
      end else begin
         req_done_o <= req_go;
         cmp_done_o <= cmp_go;
         msg_done_o <= msg_go;
         if (req_go) req_addr_o <= step[RING_REQ] ? saddr[RING_REQ] : '0;
         if (cmp_go) cmp_addr_o <= saddr[RING_CMP];
         if (msg_go) msg_addr_o <= saddr[RING_MSG];
      end
   end

   // ---------------- ring-state file ----------------
   logic [NUM_FIELDS-1:0]       dev_we;
   logic [IDX_W-1:0]            dev_d [NUM_FIELDS];
   logic [NUM_FIELDS*IDX_W-1:0] dev_flat, fields_flat;

   always_comb begin
      dev_we = '0;
      for (int f = 0; f < NUM_FIELDS; f++) dev_d[f] = '0;
      dev_we[F_REQ_PROD] = init[RING_REQ];
      dev_we[F_REQ_CONS] = init[RING_REQ] | req_flush_i;
      dev_d[F_REQ_CONS]  = init[RING_REQ] ? '0 : cnt[RING_REQ];
      dev_we[F_REQ_LOG2] = init[RING_REQ];
      dev_d[F_REQ_LOG2]  = log2v[RING_REQ];
      dev_we[F_CMP_PROD] = init[RING_CMP] | cmp_flush_i;
      dev_d[F_CMP_PROD]  = init[RING_CMP] ? '0 : cnt[RING_CMP];
      dev_we[F_CMP_CONS] = init[RING_CMP];
      dev_we[F_CMP_LOG2] = init[RING_CMP];
      dev_d[F_CMP_LOG2]  = log2v[RING_CMP];
      dev_we[F_MSG_PROD] = init[RING_MSG] | msg_flush_i;
      dev_d[F_MSG_PROD]  = init[RING_MSG] ? '0 : cnt[RING_MSG];
      dev_we[F_MSG_CONS] = init[RING_MSG];
      dev_we[F_MSG_LOG2] = init[RING_MSG];
      dev_d[F_MSG_LOG2]  = log2v[RING_MSG];
      for (int f = 0; f < NUM_FIELDS; f++) dev_flat[f*IDX_W +: IDX_W] = dev_d[f];
   end

   ring_state_file #(
      .FIELDS (NUM_FIELDS),
      .W      (IDX_W),
      .AW     (FLD_AW)
   ) u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_we_i    (sh_we_i),
      .host_waddr_i (sh_waddr_i),
      .host_wdata_i (sh_wdata_i),
      .dev_we_i     (dev_we),
      .dev_wdata_i  (dev_flat),
      .fields_o     (fields_flat)
   );

   always_comb begin
      sh_rdata_o = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         fld[f] = fields_flat[f*IDX_W +: IDX_W];
         if (sh_raddr_i == FLD_AW'(f)) sh_rdata_o = fld[f];
      end
   end

   logic [IDX_W:0] msg_used, msg_len;
   assign msg_used   = {1'b0, fld[F_MSG_PROD] - fld[F_MSG_CONS]};
   assign msg_len    = {1'b0, mask[RING_MSG]} + 1'b1;
   assign msg_room_o = (msg_used < msg_len);

   // ---------------- assertions ----------------
   assert_cleanup_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clean_i |=> (cnt[RING_REQ] == '0 && cnt[RING_CMP] == '0 && cnt[RING_MSG] == '0 &&
                   mask[RING_REQ] == '0 && mask[RING_CMP] == '0 && mask[RING_MSG] == '0));

   assert_setup_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init[RING_REQ] |=> (fld[F_REQ_PROD] == '0 && fld[F_CMP_PROD] == '0 &&
                          cnt[RING_REQ] == '0 && cnt[RING_CMP] == '0));

   assert_empty_pop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_go && req_empty) |=> (req_addr_o == '0 && $stable(cnt[RING_REQ])));

   assert_pop_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_go && !req_empty) |=> cnt[RING_REQ] == $past(cnt[RING_REQ]) + 1'b1);

   assert_cmp_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_go |=> cnt[RING_CMP] == $past(cnt[RING_CMP]) + 1'b1);

   assert_req_publish_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_flush_i && !init[RING_REQ]) |=> fld[F_REQ_CONS] == $past(cnt[RING_REQ]));

   assert_done_follows_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_done_o) |-> $past(req_pop_i));

endmodule

// File: tb/ring_index_mgr_test.sv
`timescale 1ns/1ps
module ring_index_mgr_test;

   localparam int PS  = 8;
   localparam int AW  = 32;
   localparam int MP  = 4;
   localparam int RD  = 128;
   localparam int CD  = 32;
   localparam int MD  = 128;
   localparam int PPW = AW - PS;
   localparam int NPW = $clog2(MP + 1);

   logic clk = 1'b0;
   logic rst_n;
   logic clean_i, rings_setup_i, msg_setup_i;
   logic [NPW-1:0] req_npages_i, cmp_npages_i, msg_npages_i;
   logic [MP*PPW-1:0] req_ppns_i, cmp_ppns_i, msg_ppns_i;
   logic req_pop_i, cmp_pop_i, msg_pop_i;
   logic req_flush_i, cmp_flush_i, msg_flush_i;
   logic [AW-1:0] req_addr_o, cmp_addr_o, msg_addr_o;
   logic req_done_o, cmp_done_o, msg_done_o, msg_room_o;
   logic sh_we_i;
   logic [3:0] sh_waddr_i, sh_raddr_i;
   logic [31:0] sh_wdata_i, sh_rdata_o;

   ring_index_mgr #(
      .PAGE_SHIFT(PS), .ADDR_W(AW), .MAX_PAGES(MP),
      .REQ_DESC_BYTES(RD), .CMP_DESC_BYTES(CD), .MSG_DESC_BYTES(MD)
   ) uut (
      .clk(clk), .rst_n(rst_n), .clean_i(clean_i),
      .rings_setup_i(rings_setup_i),
      .req_npages_i(req_npages_i), .req_ppns_i(req_ppns_i),
      .cmp_npages_i(cmp_npages_i), .cmp_ppns_i(cmp_ppns_i),
      .msg_setup_i(msg_setup_i),
      .msg_npages_i(msg_npages_i), .msg_ppns_i(msg_ppns_i),
      .req_pop_i(req_pop_i), .cmp_pop_i(cmp_pop_i), .msg_pop_i(msg_pop_i),
      .req_flush_i(req_flush_i), .cmp_flush_i(cmp_flush_i), .msg_flush_i(msg_flush_i),
      .req_addr_o(req_addr_o), .req_done_o(req_done_o),
      .cmp_addr_o(cmp_addr_o), .cmp_done_o(cmp_done_o),
      .msg_addr_o(msg_addr_o), .msg_done_o(msg_done_o),
      .msg_room_o(msg_room_o),
      .sh_we_i(sh_we_i), .sh_waddr_i(sh_waddr_i), .sh_wdata_i(sh_wdata_i),
      .sh_raddr_i(sh_raddr_i), .sh_rdata_o(sh_rdata_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int errors = 0;

   // scoreboard queues, one per ring
   logic [AW-1:0] q_req[$];
   logic [AW-1:0] q_cmp[$];
   logic [AW-1:0] q_msg[$];

   // reference model state
   logic [31:0]   m_cnt  [3];
   logic [31:0]   m_mask [3];
   logic [AW-1:0] m_base [3][MP];
   logic [31:0]   m_req_prod;
   int per_page [3] = '{2, 8, 2};
   int desc_sz  [3] = '{RD, CD, MD};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] model_addr(input int r);
      logic [31:0] slot;
      slot = m_cnt[r] & m_mask[r];
      return m_base[r][slot / per_page[r]] + AW'((slot % per_page[r]) * desc_sz[r]);
   endfunction

   // monitor: pops the expected item when the design reports a result
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (req_done_o) begin
            if (q_req.size() == 0) chk("R10 request done without pop", 1, 0);
            else chk("R4/R5 request slot address", req_addr_o, q_req.pop_front());
         end
         if (cmp_done_o) begin
            if (q_cmp.size() == 0) chk("R10 completion done without pop", 1, 0);
            else chk("R6 completion slot address", cmp_addr_o, q_cmp.pop_front());
         end
         if (msg_done_o) begin
            if (q_msg.size() == 0) chk("R10 message done without pop", 1, 0);
            else chk("R5 message slot address", msg_addr_o, q_msg.pop_front());
         end
      end
   end

   task automatic rd(input int f, input logic [31:0] exp, input string tag);
      sh_raddr_i = 4'(f);
      #1;
      chk(tag, sh_rdata_o, exp);
   endtask

   task automatic host_wr(input int f, input logic [31:0] d);
      @(negedge clk);
      sh_we_i = 1'b1; sh_waddr_i = 4'(f); sh_wdata_i = d;
      if (f == 0) m_req_prod = d;
      @(negedge clk);
      sh_we_i = 1'b0;
   endtask

   task automatic drive_pop(input int r, input logic v);
      case (r)
         0: req_pop_i = v;
         1: cmp_pop_i = v;
         default: msg_pop_i = v;
      endcase
   endtask

   // driver: back-to-back pops, expected results pushed to the scoreboard
   task automatic pops(input int r, input int n);
      for (int i = 0; i < n; i++) begin
         logic [AW-1:0] e;
         @(negedge clk);
         drive_pop(r, 1'b1);
         if (r == 0 && m_req_prod == m_cnt[0]) e = '0;
         else begin
            e = model_addr(r);
            m_cnt[r] = m_cnt[r] + 1;
         end
         case (r)
            0: q_req.push_back(e);
            1: q_cmp.push_back(e);
            default: q_msg.push_back(e);
         endcase
      end
      @(negedge clk);
      drive_pop(r, 1'b0);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_flush(input int r);
      @(negedge clk);
      case (r)
         0: req_flush_i = 1'b1;
         1: cmp_flush_i = 1'b1;
         default: msg_flush_i = 1'b1;
      endcase
      @(negedge clk);
      req_flush_i = 1'b0; cmp_flush_i = 1'b0; msg_flush_i = 1'b0;
   endtask

   initial begin
      #(20 * 50000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      clean_i = 0; rings_setup_i = 0; msg_setup_i = 0;
      req_npages_i = '0; cmp_npages_i = '0; msg_npages_i = '0;
      req_ppns_i = '0; cmp_ppns_i = '0; msg_ppns_i = '0;
      req_pop_i = 0; cmp_pop_i = 0; msg_pop_i = 0;
      req_flush_i = 0; cmp_flush_i = 0; msg_flush_i = 0;
      sh_we_i = 0; sh_waddr_i = '0; sh_wdata_i = '0; sh_raddr_i = '0;
      m_req_prod = 0;
      for (int r = 0; r < 3; r++) begin
         m_cnt[r] = 0; m_mask[r] = 0;
         for (int p = 0; p < MP; p++) m_base[r][p] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      for (int f = 0; f < 9; f++) rd(f, 0, "R1 reset clears ring-state field");
      chk("R10 no done after reset", {req_done_o, cmp_done_o, msg_done_o}, 0);
      chk("R7 room with empty zero-length ring", msg_room_o, 1);

      // message setup before ring setup is ignored
      host_wr(6, 32'h33);
      msg_npages_i = 2; msg_ppns_i = '0;
      msg_ppns_i[0*PPW +: PPW] = 24'h70; msg_ppns_i[1*PPW +: PPW] = 24'h71;
      @(negedge clk); msg_setup_i = 1; @(negedge clk); msg_setup_i = 0;
      rd(6, 32'h33, "R8 early message setup leaves producer field");
      rd(8, 0, "R8 early message setup leaves log2 field");

      // ring setup
      host_wr(0, 5);
      req_npages_i = 3;
      for (int p = 0; p < MP; p++) req_ppns_i[p*PPW +: PPW] = PPW'(32'h11 * (p + 1));
      cmp_npages_i = 2;
      for (int p = 0; p < MP; p++) cmp_ppns_i[p*PPW +: PPW] = PPW'(32'h50 + 16 * p);
      @(negedge clk); rings_setup_i = 1; @(negedge clk); rings_setup_i = 0;
      m_req_prod = 0;
      m_cnt[0] = 0; m_mask[0] = 7;
      m_cnt[1] = 0; m_mask[1] = 15;
      for (int p = 0; p < MP; p++) begin
         m_base[0][p] = (p < 3) ? AW'((32'h11 * (p + 1)) << PS) : '0;
         m_base[1][p] = (p < 2) ? AW'((32'h50 + 16 * p) << PS) : '0;
      end
      rd(0, 0, "R2 setup clears request producer");
      rd(1, 0, "R2 setup clears request consumer");
      rd(2, 3, "R3 request log2 for six entries");
      rd(3, 0, "R2 setup clears completion producer");
      rd(5, 4, "R3 completion log2 for sixteen entries");
      rd(6, 32'h33, "R2 ring setup leaves message field");

      // empty request ring
      pops(0, 1);
      // ten posted requests, two extra pops find the ring empty
      host_wr(0, 10);
      pops(0, 12);
      pulse_flush(0);
      rd(1, 10, "R9 request flush publishes unmasked counter");

      // completion ring wraps with no overflow check
      pops(1, 20);
      pulse_flush(1);
      rd(3, 20, "R6 R9 completion counter past ring length");

      // message setup now accepted
      @(negedge clk); msg_setup_i = 1; @(negedge clk); msg_setup_i = 0;
      m_cnt[2] = 0; m_mask[2] = 3;
      m_base[2][0] = AW'(32'h70 << PS); m_base[2][1] = AW'(32'h71 << PS);
      rd(6, 0, "R8 message setup clears producer");
      rd(8, 2, "R3 R8 message log2 for four entries");

      // room test
      host_wr(6, 4); host_wr(7, 0);
      #1 chk("R7 full message ring", msg_room_o, 0);
      host_wr(7, 1);
      #1 chk("R7 one free message slot", msg_room_o, 1);
      host_wr(6, 2); host_wr(7, 32'hFFFF_FFFF);
      #1 chk("R7 room across index wrap", msg_room_o, 1);
      host_wr(7, 32'hFFFF_FFFE);
      #1 chk("R7 full across index wrap", msg_room_o, 0);

      pops(2, 5);
      pulse_flush(2);
      rd(6, 5, "R9 message flush publishes counter");

      // block write wins over host write on the same field
      @(negedge clk);
      req_flush_i = 1; sh_we_i = 1; sh_waddr_i = 4'd1; sh_wdata_i = 32'hDEAD;
      @(negedge clk);
      req_flush_i = 0; sh_we_i = 0;
      rd(1, 10, "R10 block write wins field collision");

      // cleanup
      @(negedge clk); clean_i = 1; @(negedge clk); clean_i = 0;
      for (int r = 0; r < 3; r++) begin
         m_cnt[r] = 0; m_mask[r] = 0;
         for (int p = 0; p < MP; p++) m_base[r][p] = '0;
      end
      pulse_flush(0); pulse_flush(1); pulse_flush(2);
      rd(1, 0, "R1 cleanup clears request counter");
      rd(3, 0, "R1 cleanup clears completion counter");
      rd(6, 0, "R1 cleanup clears message counter");
      rd(0, 10, "R1 cleanup leaves ring-state file");
      pops(0, 1);   // not empty (10 vs 0): page bases cleared, address 0
      @(negedge clk); msg_setup_i = 1; @(negedge clk); msg_setup_i = 0;
      rd(8, 2, "R8 message setup after cleanup ignored");

      // one-page request ring: two entries, mask 1
      req_npages_i = 1;
      req_ppns_i = '0; req_ppns_i[0 +: PPW] = 24'h09;
      @(negedge clk); rings_setup_i = 1; @(negedge clk); rings_setup_i = 0;
      m_req_prod = 0; m_cnt[0] = 0; m_mask[0] = 1; m_cnt[1] = 0; m_mask[1] = 15;
      m_base[0][0] = AW'(32'h09 << PS);
      rd(2, 1, "R3 one-page request log2");
      host_wr(0, 3);
      pops(0, 3);

      repeat (3) @(negedge clk);
      chk("R10 all request pops answered", q_req.size(), 0);
      chk("R10 all completion pops answered", q_cmp.size(), 0);
      chk("R10 all message pops answered", q_msg.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule